// File: doc/BRIEF.md
# Byte-Wide Configuration Bank with Pad Function Select

This block holds the configuration registers of a small serial-bus target. It sits behind a plain register read/write port. The bit-level bus engine that frames transactions lives elsewhere and only presents an address, a write strobe and a data byte. Reads return data combinationally for the address on the port.

There are four locations:
- the target's own bus address;
- a control byte carrying an analog-output-disable bit and a self-clearing soft-reset trigger;
- a pad configuration byte;
- a one-bit general-purpose output value.

The pad configuration byte sets four things for one general-purpose pad:
- which internal source the pad drives (the output register bit, clock loss, clock presence or the power-on flag);
- the pull resistors;
- the input buffer enable;
- the output driver enable.

A soft reset puts every location except the bus address back to its power-up value. The bus address therefore survives a software-initiated restart.

Top module: `cfgbank_top`

## Requirements
- R1: Location 0x00 holds a 7-bit bus address in bits 7:1, power-up value 0x57, so it reads 0xAE after power-up. A write stores bits 7:1 of the data, and bit 0 always reads 0.
- R2: A write to 0x01 with data bit 0 set is a soft reset. At the clock edge ending that write, locations 0x01, 0x02 and 0x03 return to their power-up values, and location 0x00 keeps its current value.
- R3: The soft reset takes exactly the one cycle of the write. Bit 0 of 0x01 reads 0 at all times, including the cycle right after the trigger. When a trigger write also has bit 4 set, the soft reset wins and bit 4 stays 0.
- R4: Bit 4 of 0x01 drives `analog_off` and is 0 after power-up. The other bits of 0x01 ignore writes and read 0.
- R5: Bits 7:4 of 0x02 choose the pad output source:
  - 0x0: bit 0 of location 0x03;
  - 0x3: `clk_loss`;
  - 0x4: `clk_seen`;
  - 0x6: `por_flag`.
- R6: Any other value in bits 7:4 of 0x02 drives `pad_out` to 0.
- R7: Bits 3:2 of 0x02 set the pulls, power-up value 01:
  - 00: no pull;
  - 01: `pull_dn`;
  - 10: `pull_up`;
  - 11: stored and read back unchanged, with neither pull active.
- R8: Bit 1 of 0x02 drives `pad_ie` (power-up 0). Bit 0 drives `pad_oe` (power-up 1). Location 0x02 reads 0x05 after power-up and reads back any written byte.
- R9: Location 0x03 stores data bit 0, which is 0 after power-up. Its bits 7:1 read 0.
- R10: Any address above 0x03 reads 0x00, and a write to it changes no location.
- R11: A low level on `por_n` puts all four locations, including the bus address, back to their power-up values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `reg_addr`, combinational |
| clk_loss | input | 1 | Status: reference clock lost |
| clk_seen | input | 1 | Status: reference clock present |
| por_flag | input | 1 | Status: power-on reset flag |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output driver enable (0 = high impedance) |
| pad_ie | output | 1 | Pad input buffer enable |
| pull_up | output | 1 | Pad pull-up enable |
| pull_dn | output | 1 | Pad pull-down enable |
| analog_off | output | 1 | Analog output buffer disable |

## Verification
The bench loads a non-default value into every location, including the bus address, and then fires a soft reset. A design that also cleared the address would make the target drop off the bus, and one that stored the trigger bit would read back a 1 in the following cycle. It sweeps all sixteen source codes against all sixteen combinations of output bit and status inputs, which catches a reserved code leaking a status signal onto the pad. It also writes 0xFF to every unmapped address, so a partial address decode that aliases a real location shows up as a corrupted read-back. Each pull code is checked against both pull outputs, so a design that turned on both pulls for the reserved code would be caught.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam logic [7:0] LOC_ID   = 8'h00;
  localparam logic [7:0] LOC_CTRL = 8'h01;
  localparam logic [7:0] LOC_PAD  = 8'h02;
  localparam logic [7:0] LOC_GPO  = 8'h03;

  localparam int CTRL_TRIG_BIT = 0;
  localparam int CTRL_ANA_BIT  = 4;

  typedef enum logic [3:0] {
    SRC_GPO  = 4'h0,
    SRC_LOSS = 4'h3,
    SRC_SEEN = 4'h4,
    SRC_POR  = 4'h6
  } src_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;

  typedef struct packed {
    logic [3:0] src;
    logic [1:0] pull;
    logic       ie;
    logic       oe;
  } pad_cfg_t;

  localparam pad_cfg_t PAD_CFG_INIT = '{src: 4'h0, pull: 2'b01, ie: 1'b0, oe: 1'b1};

  function automatic logic pick_source(logic [3:0] src, logic gpo, logic loss,
                                       logic seen, logic por);
    case (src)
      SRC_GPO:  return gpo;
      SRC_LOSS: return loss;
      SRC_SEEN: return seen;
      SRC_POR:  return por;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] read_byte(logic [7:0] loc, logic [6:0] id,
                                           logic analog, pad_cfg_t cfg, logic gpo);
    case (loc)
      LOC_ID:   return {id, 1'b0};
      LOC_CTRL: return 8'(analog) << CTRL_ANA_BIT;
      LOC_PAD:  return cfg;
      LOC_GPO:  return {7'b0, gpo};
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [6:0] ID_DEFAULT = 7'h57
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [6:0]        id_q,
  output logic              analog_q,
  output pad_cfg_t          cfg_q,
  output logic              gpo_q,
  output logic              srst_pulse
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(LOC_ID);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(LOC_CTRL);
  localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'(LOC_PAD);
  localparam logic [ADDR_W-1:0] A_GPO  = ADDR_W'(LOC_GPO);

  logic hit_id, hit_ctrl, hit_pad, hit_gpo;

  assign hit_id     = wr_en && (wr_addr == A_ID);
  assign hit_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign hit_pad    = wr_en && (wr_addr == A_PAD);
  assign hit_gpo    = wr_en && (wr_addr == A_GPO);
  assign srst_pulse = hit_ctrl && wr_data[CTRL_TRIG_BIT];

  // Bus address: only the power-on reset touches it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      id_q <= ID_DEFAULT;
    else if (hit_id) id_q <= wr_data[7:1];
  end

  // Everything else also answers the soft-reset pulse.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      analog_q <= 1'b0;
      cfg_q    <= PAD_CFG_INIT;
      gpo_q    <= 1'b0;
    end else if (srst_pulse) begin
      analog_q <= 1'b0;
      cfg_q    <= PAD_CFG_INIT;
      gpo_q    <= 1'b0;
    end else begin
      if (hit_ctrl) analog_q <= wr_data[CTRL_ANA_BIT];
      if (hit_pad)  cfg_q    <= wr_data;
      if (hit_gpo)  gpo_q    <= wr_data[0];
    end
  end

endmodule

// File: rtl/cfgbank_pad.sv
module cfgbank_pad
  import cfgbank_pkg::*;
(
  input  pad_cfg_t cfg,
  input  logic     gpo,
  input  logic     clk_loss,
  input  logic     clk_seen,
  input  logic     por_flag,
  output logic     pad_out,
  output logic     pad_oe,
  output logic     pad_ie,
  output logic     pull_up,
  output logic     pull_dn
);
  assign pad_out = pick_source(cfg.src, gpo, clk_loss, clk_seen, por_flag);
  assign pad_oe  = cfg.oe;
  assign pad_ie  = cfg.ie;
  assign pull_dn = (cfg.pull == PULL_DOWN);
  assign pull_up = (cfg.pull == PULL_UP);
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [6:0] ID_DEFAULT = 7'h57
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              clk_loss,
  input  logic              clk_seen,
  input  logic              por_flag,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_ie,
  output logic              pull_up,
  output logic              pull_dn,
  output logic              analog_off
);
  localparam int LOC_MAX = 3;

  logic [6:0] id_q;
  logic       analog_q;
  pad_cfg_t   cfg_q;
  logic       gpo_q;
  logic       srst_pulse;
  logic [3:0] pad_src;
  logic       addr_in_map;

  cfgbank_regs #(.ADDR_W(ADDR_W), .ID_DEFAULT(ID_DEFAULT)) regs_i (
    .clk        (clk),
    .por_n      (por_n),
    .wr_en      (wr_en),
    .wr_addr    (reg_addr),
    .wr_data    (wr_data),
    .id_q       (id_q),
    .analog_q   (analog_q),
    .cfg_q      (cfg_q),
    .gpo_q      (gpo_q),
    .srst_pulse (srst_pulse)
  );

  cfgbank_pad pad_i (
    .cfg      (cfg_q),
    .gpo      (gpo_q),
    .clk_loss (clk_loss),
    .clk_seen (clk_seen),
    .por_flag (por_flag),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_ie   (pad_ie),
    .pull_up  (pull_up),
    .pull_dn  (pull_dn)
  );

  assign pad_src     = cfg_q.src;
  assign addr_in_map = (reg_addr <= ADDR_W'(LOC_MAX));
  assign analog_off  = analog_q;

  always_comb begin
    if (addr_in_map)
      rd_data = read_byte(8'(reg_addr), id_q, analog_q, cfg_q, gpo_q);
    else
      rd_data = 8'h00;
  end

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        rd_data,
  input logic              pad_out,
  input logic              pad_oe,
  input logic              pad_ie,
  input logic              pull_up,
  input logic              pull_dn,
  input logic              analog_off,
  input logic              clk_loss,
  input logic [6:0]        id_q,
  input logic [3:0]        pad_src,
  input logic              srst_pulse
);
  logic src_reserved;
  assign src_reserved = !(pad_src == 4'h0 || pad_src == 4'h3 ||
                          pad_src == 4'h4 || pad_src == 4'h6);

  a_r1_id_lsb_zero: assert property (@(posedge clk) disable iff (!por_n)
    (reg_addr == ADDR_W'(0)) |-> (rd_data[0] == 1'b0));

  a_r2_id_survives: assert property (@(posedge clk) disable iff (!por_n)
    srst_pulse |=> $stable(id_q));

  a_r2_defaults_back: assert property (@(posedge clk) disable iff (!por_n)
    srst_pulse |=> (!analog_off && pad_oe && !pad_ie && pull_dn && !pull_up));

  a_r3_trigger_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
    (reg_addr == ADDR_W'(1)) |-> (rd_data[0] == 1'b0));

  a_r5_loss_routed: assert property (@(posedge clk) disable iff (!por_n)
    (pad_src == 4'h3) |-> (pad_out == clk_loss));

  a_r6_reserved_low: assert property (@(posedge clk) disable iff (!por_n)
    src_reserved |-> !pad_out);

  a_r7_pulls_exclusive: assert property (@(posedge clk) disable iff (!por_n)
    !(pull_up && pull_dn));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!por_n)
    (reg_addr > ADDR_W'(3)) |-> (rd_data == 8'h00));
endmodule

bind cfgbank_top cfgbank_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .por_n      (por_n),
  .reg_addr   (reg_addr),
  .rd_data    (rd_data),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_ie     (pad_ie),
  .pull_up    (pull_up),
  .pull_dn    (pull_dn),
  .analog_off (analog_off),
  .clk_loss   (clk_loss),
  .id_q       (id_q),
  .pad_src    (pad_src),
  .srst_pulse (srst_pulse)
);

// File: tb/cfgbank_top_tb_top.sv
`timescale 1ns/1ps
module cfgbank_top_tb_top;
  logic       clk = 1'b0;
  logic       por_n;
  logic [7:0] reg_addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       clk_loss, clk_seen, por_flag;
  logic       pad_out, pad_oe, pad_ie, pull_up, pull_dn, analog_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cfgbank_top dut_i (
    .clk(clk), .por_n(por_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_loss(clk_loss),
    .clk_seen(clk_seen), .por_flag(por_flag), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_ie(pad_ie), .pull_up(pull_up), .pull_dn(pull_dn),
    .analog_off(analog_off)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic exp_pad(input logic [3:0] m, input logic [3:0] s);
    if (m == 4'd0) return s[0];
    if (m == 4'd3) return s[1];
    if (m == 4'd4) return s[2];
    if (m == 4'd6) return s[3];
    return 1'b0;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    por_n = 1'b0; wr_en = 1'b0; reg_addr = 8'h00; wr_data = 8'h00;
    clk_loss = 1'b0; clk_seen = 1'b0; por_flag = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R11 power-up values
    rd(8'h00, v); check("R11/R1 id reset", v, 8'hAE);
    rd(8'h01, v); check("R11/R4 ctrl reset", v, 8'h00);
    rd(8'h02, v); check("R11/R8 pad reset", v, 8'h05);
    rd(8'h03, v); check("R11/R9 gpo reset", v, 8'h00);
    check("R8 oe/ie reset", {pad_oe, pad_ie}, 2'b10);
    check("R7 pull reset", {pull_up, pull_dn}, 2'b01);
    check("R4 analog reset", analog_off, 1'b0);

    // R1 address write, bit 0 dropped
    wr(8'h00, 8'h35); rd(8'h00, v); check("R1 id write", v, 8'h34);

    // R4 analog bit, other bits ignored (bit 0 clear, so no soft reset)
    wr(8'h01, 8'hFE); rd(8'h01, v); check("R4 ctrl readback", v, 8'h10);
    check("R4 analog on", analog_off, 1'b1);
    wr(8'h01, 8'h00); check("R4 analog off", analog_off, 1'b0);

    // R7 / R8 pulls and buffers
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 4; b++) begin
        wr(8'h02, {4'h0, 2'(p), 2'(b)});
        rd(8'h02, v); check("R8 pad readback", v, {4'h0, 2'(p), 2'(b)});
        check("R7 pull_dn", pull_dn, p == 1);
        check("R7 pull_up", pull_up, p == 2);
        check("R8 pad_ie", pad_ie, b[1]);
        check("R8 pad_oe", pad_oe, b[0]);
      end
    end

    // R5 / R6 source select sweep
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        wr(8'h03, {7'h0, s[0]});
        wr(8'h02, {4'(m), 4'b0101});
        clk_loss = s[1]; clk_seen = s[2]; por_flag = s[3];
        #1;
        if (m == 0 || m == 3 || m == 4 || m == 6)
          check("R5 pad source", pad_out, exp_pad(4'(m), 4'(s)));
        else
          check("R6 reserved low", pad_out, 1'b0);
      end
    end
    clk_loss = 1'b0; clk_seen = 1'b0; por_flag = 1'b0;

    // R9 gpo location
    wr(8'h03, 8'hFF); rd(8'h03, v); check("R9 gpo readback", v, 8'h01);

    // R10 unmapped addresses
    wr(8'h01, 8'h10);
    wr(8'h02, 8'hF2);
    for (int a = 4; a < 256; a++) begin
      wr(8'(a), 8'hFF);
      rd(8'(a), v); check("R10 unmapped read", v, 8'h00);
    end
    rd(8'h00, v); check("R10 id intact", v, 8'h34);
    rd(8'h01, v); check("R10 ctrl intact", v, 8'h10);
    rd(8'h02, v); check("R10 pad intact", v, 8'hF2);
    rd(8'h03, v); check("R10 gpo intact", v, 8'h01);

    // R2 / R3 soft reset with bit 4 also set
    wr(8'h01, 8'h11);
    rd(8'h01, v); check("R3 trigger reads 0 next cycle", v, 8'h00);
    check("R3 analog stays 0", analog_off, 1'b0);
    rd(8'h02, v); check("R2 pad back to default", v, 8'h05);
    rd(8'h03, v); check("R2 gpo back to default", v, 8'h00);
    rd(8'h00, v); check("R2 id kept", v, 8'h34);
    @(negedge clk);
    rd(8'h02, v); check("R3 no further reset", v, 8'h05);
    wr(8'h02, 8'h3A);
    @(negedge clk);
    rd(8'h02, v); check("R3 reset lasts one cycle", v, 8'h3A);

    // R11 power-on reset also restores the address
    por_n = 1'b0; #1; por_n = 1'b1;
    rd(8'h00, v); check("R11 id reset again", v, 8'hAE);
    rd(8'h02, v); check("R11 pad reset again", v, 8'h05);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule